// File: doc/BRIEF.md
# Edge-Based Speed Phase Comparator

This block sits at the front of a motor speed loop. It compares a reference clock with a tachometer signal taken from the phase-1 Hall comparator and reports the phase difference as a pair of error pulses. The speed-up pulse starts on a falling edge of the reference. The slow-down pulse starts on a rising edge of the tachometer. Both pulses stop once each side has produced its edge. A downstream loop filter integrates the pulse pair into a torque command. When the loop is in regulation there is one tachometer rising edge for every reference falling edge.

Both inputs are asynchronous, so each one is synchronized into the system clock domain before its edges are detected. The synchronized tachometer level is also driven out on its own pin. After each comparison, the width of the error pulse is compared with a programmable threshold, and the result is a raw in-phase flag for a lock supervisor. A stop control forces the error outputs to idle so that the drive is cut and the motor coasts.

Top module: `spd_phase_cmp`

## Requirements
- R1: After reset, `speed_up_o`, `slow_down_o`, `tach_o` and `in_phase_o` are all low.
- R2: A high-to-low transition on `ref_clk_i` raises `speed_up_o` SYNC_STAGES+1 clock edges later. When the reference edge leads the tachometer edge by D cycles, the speed-up pulse is exactly D cycles wide.
- R3: A low-to-high transition on `hall1_i` raises `slow_down_o` SYNC_STAGES+1 clock edges later. When the tachometer edge leads by D cycles, the slow-down pulse is exactly D cycles wide.
- R4: A pulse ends on the clock edge that follows the arrival of the opposing edge. When both edges arrive in the same cycle, no pulse is produced. The two outputs are never high together.
- R5: While `speed_up_o` is high, further reference falling edges neither extend it nor produce a slow-down pulse. Only a tachometer rising edge ends it.
- R6: While `stop_i` is high (1 = stop), both error outputs stay low, input edges start no pulse, and `in_phase_o` is low.
- R7: `tach_o` follows `hall1_i` through SYNC_STAGES flops. A change at the input shows on `tach_o` after exactly SYNC_STAGES clock edges.
- R8: At the end of each comparison, `in_phase_o` is set to (pulse width in cycles < `lock_thresh_i`). A coincident pair of edges counts as width 0.
- R9: The pulse-width count saturates at 2^CNT_W-1 and does not wrap. A pulse longer than the counter range is therefore never reported as in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| hall1_i | input | 1 | Digitized phase-1 Hall signal (tachometer) |
| stop_i | input | 1 | 1 = stop mode, 0 = run |
| lock_thresh_i | input | CNT_W | In-phase width threshold in system clocks |
| speed_up_o | output | 1 | Error pulse: reference leads |
| slow_down_o | output | 1 | Error pulse: tachometer leads |
| tach_o | output | 1 | Synchronized tachometer mirror |
| in_phase_o | output | 1 | Last comparison narrower than threshold |

## Verification
The bench builds the block with SYNC_STAGES=3, which moves the synchronizer latency away from the default. A latency written for two stages therefore shows up in both the tach-mirror timing and the pulse-start timing. CNT_W=4 makes the width counter only 15 cycles deep, so a 20-cycle lead can exercise saturation against a wrapping counter. With a threshold of 6, the cases D=5 and D=6 fall on either side of the in-phase boundary.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef struct packed {
      logic up;
      logic dn;
   } pfd_state_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_CNT_W       = 2;
endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < spc_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("spc_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spc_edge.sv
module spc_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic hit_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   if (RISING) begin : g_rise
      assign hit_o = lvl_i & ~prev_q;
   end else begin : g_fall
      assign hit_o = ~lvl_i & prev_q;
   end
endmodule

// File: rtl/spc_pfd.sv
module spc_pfd (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stop_i,
   input  logic ref_hit_i,
   input  logic tach_hit_i,
   output logic up_o,
   output logic dn_o,
   output logic busy_o,
   output logic done_o
);
   import spc_pkg::*;

   pfd_state_t st_q, st_d;

   always_comb begin
      st_d.up = st_q.up | ref_hit_i;
      st_d.dn = st_q.dn | tach_hit_i;
      if (st_d.up && st_d.dn) st_d = '0;
      if (stop_i)             st_d = '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= st_d;
   end

   assign up_o   = st_q.up;
   assign dn_o   = st_q.dn;
   assign busy_o = st_q.up | st_q.dn;
   assign done_o = !stop_i && ((st_q.up && tach_hit_i) || (st_q.dn && ref_hit_i) ||
                               (ref_hit_i && tach_hit_i && !(st_q.up || st_q.dn)));

   p_one_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(up_o && dn_o));
   p_up_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_hit_i && !tach_hit_i && !dn_o && !stop_i) |=> up_o);
   p_dn_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tach_hit_i && !ref_hit_i && !up_o && !stop_i) |=> dn_o);
   p_up_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_o && !tach_hit_i && !stop_i) |=> up_o);
   p_stop_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!up_o && !dn_o));
endmodule

// File: rtl/spc_width.sv
module spc_width #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stop_i,
   input  logic             busy_i,
   input  logic             done_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic             in_phase_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] width;
   logic             inph_q;

   if (CNT_W < spc_pkg::MIN_CNT_W) begin : g_bad_width
      $error("spc_width: CNT_W must be at least 2");
   end

   assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
   assign width   = busy_i ? cnt_inc : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         inph_q <= 1'b0;
      end else if (stop_i) begin
         cnt_q  <= '0;
         inph_q <= 1'b0;
      end else if (done_i) begin
         cnt_q  <= '0;
         inph_q <= (width < thresh_i);
      end else if (busy_i) begin
         cnt_q  <= cnt_inc;
      end
   end

   assign in_phase_o = inph_q;

   p_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX && busy_i && !done_i && !stop_i) |=> (cnt_q == CNT_MAX));
   p_stop_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> !in_phase_o);
endmodule

// File: rtl/spd_phase_cmp.sv
module spd_phase_cmp #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_clk_i,
   input  logic             hall1_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] lock_thresh_i,
   output logic             speed_up_o,
   output logic             slow_down_o,
   output logic             tach_o,
   output logic             in_phase_o
);
   logic ref_s, tach_s;
   logic ref_hit, tach_hit;
   logic busy, done;

   spc_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ref_clk_i), .q_o(ref_s));
   spc_sync #(.STAGES(SYNC_STAGES)) u_tach_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hall1_i), .q_o(tach_s));

   spc_edge #(.RISING(1'b0)) u_ref_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(ref_s), .hit_o(ref_hit));
   spc_edge #(.RISING(1'b1)) u_tach_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(tach_s), .hit_o(tach_hit));

   spc_pfd u_pfd (
      .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i),
      .ref_hit_i(ref_hit), .tach_hit_i(tach_hit),
      .up_o(speed_up_o), .dn_o(slow_down_o), .busy_o(busy), .done_o(done));

   spc_width #(.CNT_W(CNT_W)) u_width (
      .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .busy_i(busy),
      .done_i(done), .thresh_i(lock_thresh_i), .in_phase_o(in_phase_o));

   assign tach_o = tach_s;
endmodule

// File: tb/spd_phase_cmp_tb_top.sv
`timescale 1ns/1ps
module spd_phase_cmp_tb_top;
   localparam int unsigned NS = 3;
   localparam int unsigned CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_clk = 1'b1;
   logic hall = 1'b0;
   logic stop = 1'b0;
   logic [CW-1:0] thr = CW'(6);
   logic up, dn, tach, inph;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   spd_phase_cmp #(.SYNC_STAGES(NS), .CNT_W(CW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .hall1_i(hall),
      .stop_i(stop), .lock_thresh_i(thr), .speed_up_o(up), .slow_down_o(dn),
      .tach_o(tach), .in_phase_o(inph));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      ref_clk = 1'b1;
      hall    = 1'b0;
      for (int i = 0; i < NS + 3; i++) @(negedge clk);
   endtask

   // Lead of d cycles; ref_first selects which edge comes first.
   task automatic run_cmp(input bit ref_first, input int d,
                          output int ups, output int dns);
      ups = 0; dns = 0;
      @(negedge clk);
      if (ref_first || d == 0) ref_clk = 1'b0;
      if (!ref_first || d == 0) hall = 1'b1;
      for (int i = 1; i <= d + NS + 6; i++) begin
         @(negedge clk);
         if (up) ups++;
         if (dn) dns++;
         if (up && dn) chk("R4 both high", 1, 0);
         if (i == d) begin
            if (ref_first) hall = 1'b1;
            else           ref_clk = 1'b0;
         end
      end
   endtask

   task automatic t_reset();
      chk("R1 speed_up", up, 0);
      chk("R1 slow_down", dn, 0);
      chk("R1 tach", tach, 0);
      chk("R1 in_phase", inph, 0);
   endtask

   task automatic t_up_lead();
      int u, w;
      run_cmp(1'b1, 5, u, w);
      chk("R2 up width", u, 5);
      chk("R2 no down", w, 0);
      chk("R8 width 5 < 6", inph, 1);
      settle();
   endtask

   task automatic t_up_latency();
      @(negedge clk);
      ref_clk = 1'b0;
      for (int i = 0; i < NS; i++) @(negedge clk);
      chk("R2 not yet", up, 0);
      @(negedge clk);
      chk("R2 latency", up, 1);
      hall = 1'b1;
      for (int i = 0; i < NS + 3; i++) @(negedge clk);
      chk("R4 cleared", up, 0);
      settle();
   endtask

   task automatic t_dn_lead();
      int u, w;
      run_cmp(1'b0, 7, u, w);
      chk("R3 down width", w, 7);
      chk("R3 no up", u, 0);
      chk("R8 width 7 >= 6", inph, 0);
      settle();
   endtask

   task automatic t_coincident();
      int u, w;
      run_cmp(1'b1, 0, u, w);
      chk("R4 coincident up", u, 0);
      chk("R4 coincident down", w, 0);
      chk("R8 width 0", inph, 1);
      settle();
   endtask

   task automatic t_threshold();
      int u, w;
      run_cmp(1'b1, 6, u, w);
      chk("R8 width 6 at thr", inph, 0);
      settle();
      thr = CW'(9);
      run_cmp(1'b0, 7, u, w);
      chk("R8 width 7 thr 9", inph, 1);
      settle();
      thr = CW'(6);
   endtask

   task automatic t_multi_ref();
      int u, w;
      u = 0; w = 0;
      @(negedge clk);
      ref_clk = 1'b0;
      for (int i = 1; i <= 10 + NS + 6; i++) begin
         @(negedge clk);
         if (up) u++;
         if (dn) w++;
         if (i == 3) ref_clk = 1'b1;
         if (i == 6) ref_clk = 1'b0;
         if (i == 10) hall = 1'b1;
      end
      chk("R5 up held", u, 10);
      chk("R5 no down", w, 0);
      settle();
   endtask

   task automatic t_stop();
      int u, w;
      stop = 1'b1;
      run_cmp(1'b1, 4, u, w);
      chk("R6 up idle", u, 0);
      chk("R6 down idle", w, 0);
      chk("R6 in_phase low", inph, 0);
      settle();
      stop = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_tach();
      @(negedge clk);
      hall = 1'b1;
      for (int i = 0; i < NS - 1; i++) @(negedge clk);
      chk("R7 tach early", tach, 0);
      @(negedge clk);
      chk("R7 tach mirror", tach, 1);
      ref_clk = 1'b0;
      for (int i = 0; i < NS + 3; i++) @(negedge clk);
      hall = 1'b0;
      for (int i = 0; i < NS; i++) @(negedge clk);
      chk("R7 tach low", tach, 0);
      settle();
   endtask

   task automatic t_saturate();
      int u, w;
      run_cmp(1'b1, 20, u, w);
      chk("R9 up width 20", u, 20);
      chk("R9 saturated not in phase", inph, 0);
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      settle();
      t_up_lead();
      t_up_latency();
      t_dn_lead();
      t_coincident();
      t_threshold();
      t_multi_ref();
      t_stop();
      t_tach();
      t_saturate();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule